// File: doc/BRIEF.md
# Bus-Control Pin Function Selector

This block decides what each of six bus-control and status pins on an external bus port carries. The six pins are read/write, low-byte strobe, bus clock, two instruction-pipe status lines and no-access. Each pin either carries its bus function or acts as a general-purpose pin, and the choice comes from two things: a small pin-assignment register and the operating mode. The operating mode is expanded wide, expanded narrow or emulation, and it is latched while reset is held.

For every pin the block produces four signals: the effective function select, the output value, the output enable and a pull-up request. When a pin carries its bus function, the block routes the matching internal source onto it. The bus clock pin also needs a clock source and gating. The register is read back as stored. In narrow mode the register accepts a single write after reset. Narrow mode also masks the strobe enable and ignores internal visibility.

Top module: `busctl_pinmux`

## Requirements
- R1: While `rst` is high, `mode_sel` is decoded and latched: 2'b00 is wide, 2'b01 is narrow, and 2'b10 and 2'b11 are emulation. Changes on `mode_sel` after reset have no effect.
- R2: The register fields are: bit 0 read/write enable, bit 1 strobe enable, bit 2 clock-off, bit 3 clock stretch, bit 4 pipe-status enable, bit 5 no-access enable, and bits 7:6 reserved, which read 0. The reset value is 8'h3B in wide and emulation modes and 8'h08 in narrow mode.
- R3: In wide and emulation modes, every write stores `cfg_wdata & 8'h3F`. The stored value appears on `cfg_rdata` from the clock edge that takes the write.
- R4: In narrow mode only the first write after reset is stored, and later writes are ignored. Only reset clears the lock.
- R5: Pin index to select mapping: index 0 selects from bit 0, index 1 from bit 1, index 2 from the inverse of bit 2, indices 3 and 4 both from bit 4, and index 5 from bit 5.
- R6: In narrow mode, `pin_fsel[1]` is 0 even when the stored bit 1 reads 1.
- R7: A pin with select 0 drives `gpio_dout[i]`. Its output enable equals `gpio_ddr[i]`, and its pull-up is on exactly when `gpio_ddr[i]` is 0.
- R8: A pin with select 1 has output enable 1 and pull-up 0. It drives its source: `bus_rw`, `bus_strobe`, the clock, `pipe_stat[0]`, `pipe_stat[1]` and `bus_noacc`, for pins 0 to 5 in that order.
- R9: The clock source is `bus_clk_str` when bit 3 is set and `bus_clk_raw` otherwise. The clock is forced to 0 while `int_cycle` is high unless `vis_req` is high. In narrow mode, `vis_req` is treated as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode, latched during reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Stored register value |
| bus_rw | input | 1 | Internal read/write source |
| bus_strobe | input | 1 | Internal low-byte strobe source |
| bus_clk_raw | input | 1 | Unstretched bus clock |
| bus_clk_str | input | 1 | Stretched bus clock |
| pipe_stat | input | 2 | Instruction pipe status sources |
| bus_noacc | input | 1 | No-access source |
| int_cycle | input | 1 | Current cycle is internal |
| vis_req | input | 1 | Internal visibility request |
| gpio_dout | input | 6 | General-purpose output data per pin |
| gpio_ddr | input | 6 | General-purpose direction per pin (1 = output) |
| pin_out | output | 6 | Pin output value |
| pin_oe | output | 6 | Pin output enable |
| pin_pu | output | 6 | Pin pull-up request |
| pin_fsel | output | 6 | Effective function select (1 = bus function) |

## Verification
The checks assume that `mode_sel` is stable during reset, because the latched mode is taken from the last reset cycle. They also assume that writes arrive only with reset low, because the lock assertion measures its window from the first accepted narrow-mode write. The bench changes `mode_sel` only while `rst` is high, except for one deliberate change made after reset to show that the change has no effect. It drives all other inputs away from the rising edge, so each write falls into exactly one cycle.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_PINS = 6;
    localparam int MODE_W   = 2;

    localparam int PIN_RW    = 0;
    localparam int PIN_STRB  = 1;
    localparam int PIN_CLK   = 2;
    localparam int PIN_PIPE0 = 3;
    localparam int PIN_PIPE1 = 4;
    localparam int PIN_NOACC = 5;

    localparam logic [REG_W-1:0] WRITABLE = 8'h3F;

    typedef enum logic [MODE_W-1:0] {
        OPM_WIDE   = 2'b00,
        OPM_NARROW = 2'b01,
        OPM_EMUL   = 2'b10
    } opmode_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       noacc_en;
        logic       pipe_en;
        logic       clk_stretch;
        logic       clk_off;
        logic       strobe_en;
        logic       rw_en;
    } cfg_t;

    typedef struct packed {
        logic [NUM_PINS-1:0] fsel;
        logic [NUM_PINS-1:0] src;
    } route_t;

    function automatic opmode_e decode_mode(input logic [MODE_W-1:0] m);
        case (m)
            2'b00:   return OPM_WIDE;
            2'b01:   return OPM_NARROW;
            default: return OPM_EMUL;
        endcase
    endfunction

    function automatic cfg_t cfg_reset(input opmode_e m);
        cfg_t c;
        c = '0;
        c.clk_stretch = 1'b1;
        if (m != OPM_NARROW) begin
            c.rw_en     = 1'b1;
            c.strobe_en = 1'b1;
            c.pipe_en   = 1'b1;
            c.noacc_en  = 1'b1;
        end
        return c;
    endfunction
endpackage

// File: rtl/busctl_cfg_reg.sv
module busctl_cfg_reg
    import busctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_raw,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output opmode_e           mode_q,
    output cfg_t              cfg_q,
    output logic              locked_q
);
    opmode_e mode_at_rst;
    logic    wr_ok;

    assign mode_at_rst = decode_mode(mode_raw);
    assign wr_ok       = wr_en && !((mode_q == OPM_NARROW) && locked_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= mode_at_rst;
            cfg_q    <= cfg_reset(mode_at_rst);
            locked_q <= 1'b0;
        end else begin
            if (wr_ok)
                cfg_q <= cfg_t'(wr_data & WRITABLE);
            if (wr_en && (mode_q == OPM_NARROW))
                locked_q <= 1'b1;
        end
    end
endmodule

// File: rtl/busctl_pin_sel.sv
module busctl_pin_sel
    import busctl_pkg::*;
(
    input  opmode_e    mode_q,
    input  cfg_t       cfg_q,
    input  logic       bus_rw,
    input  logic       bus_strobe,
    input  logic       bus_clk_raw,
    input  logic       bus_clk_str,
    input  logic [1:0] pipe_stat,
    input  logic       bus_noacc,
    input  logic       int_cycle,
    input  logic       vis_req,
    output route_t     route
);
    logic narrow;
    logic vis_eff;
    logic clk_src;
    logic clk_gated;

    assign narrow    = (mode_q == OPM_NARROW);
    assign vis_eff   = vis_req && !narrow;
    assign clk_src   = cfg_q.clk_stretch ? bus_clk_str : bus_clk_raw;
    assign clk_gated = clk_src && !(int_cycle && !vis_eff);

    always_comb begin
        route = '0;
        route.fsel[PIN_RW]    = cfg_q.rw_en;
        route.fsel[PIN_STRB]  = cfg_q.strobe_en && !narrow;
        route.fsel[PIN_CLK]   = !cfg_q.clk_off;
        route.fsel[PIN_PIPE0] = cfg_q.pipe_en;
        route.fsel[PIN_PIPE1] = cfg_q.pipe_en;
        route.fsel[PIN_NOACC] = cfg_q.noacc_en;

        route.src[PIN_RW]     = bus_rw;
        route.src[PIN_STRB]   = bus_strobe;
        route.src[PIN_CLK]    = clk_gated;
        route.src[PIN_PIPE0]  = pipe_stat[0];
        route.src[PIN_PIPE1]  = pipe_stat[1];
        route.src[PIN_NOACC]  = bus_noacc;
    end
endmodule

// File: rtl/busctl_pad_drv.sv
module busctl_pad_drv #(
    parameter int NP = 6
) (
    input  logic [NP-1:0] fsel,
    input  logic [NP-1:0] src,
    input  logic [NP-1:0] gpio_dout,
    input  logic [NP-1:0] gpio_ddr,
    output logic [NP-1:0] pin_out,
    output logic [NP-1:0] pin_oe,
    output logic [NP-1:0] pin_pu
);
    for (genvar i = 0; i < NP; i++) begin : g_pin
        always_comb begin
            if (fsel[i]) begin
                pin_out[i] = src[i];
                pin_oe[i]  = 1'b1;
                pin_pu[i]  = 1'b0;
            end else begin
                pin_out[i] = gpio_dout[i];
                pin_oe[i]  = gpio_ddr[i];
                pin_pu[i]  = !gpio_ddr[i];
            end
        end
    end
endmodule

// File: rtl/busctl_pinmux.sv
module busctl_pinmux
    import busctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [MODE_W-1:0]   mode_sel,
    input  logic                cfg_wr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic                bus_rw,
    input  logic                bus_strobe,
    input  logic                bus_clk_raw,
    input  logic                bus_clk_str,
    input  logic [1:0]          pipe_stat,
    input  logic                bus_noacc,
    input  logic                int_cycle,
    input  logic                vis_req,
    input  logic [NUM_PINS-1:0] gpio_dout,
    input  logic [NUM_PINS-1:0] gpio_ddr,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pu,
    output logic [NUM_PINS-1:0] pin_fsel
);
    opmode_e mode_q;
    cfg_t    cfg_q;
    logic    locked_q;
    route_t  route;

    busctl_cfg_reg i_cfg (
        .clk      (clk),
        .rst      (rst),
        .mode_raw (mode_sel),
        .wr_en    (cfg_wr),
        .wr_data  (cfg_wdata),
        .mode_q   (mode_q),
        .cfg_q    (cfg_q),
        .locked_q (locked_q)
    );

    busctl_pin_sel i_sel (
        .mode_q      (mode_q),
        .cfg_q       (cfg_q),
        .bus_rw      (bus_rw),
        .bus_strobe  (bus_strobe),
        .bus_clk_raw (bus_clk_raw),
        .bus_clk_str (bus_clk_str),
        .pipe_stat   (pipe_stat),
        .bus_noacc   (bus_noacc),
        .int_cycle   (int_cycle),
        .vis_req     (vis_req),
        .route       (route)
    );

    busctl_pad_drv #(.NP(NUM_PINS)) i_pad (
        .fsel      (route.fsel),
        .src       (route.src),
        .gpio_dout (gpio_dout),
        .gpio_ddr  (gpio_ddr),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu    (pin_pu)
    );

    assign cfg_rdata = cfg_q;
    assign pin_fsel  = route.fsel;
endmodule

// File: rtl/busctl_pinmux_chk.sv
module busctl_pinmux_chk
    import busctl_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [MODE_W-1:0]   mode_q,
    input logic                locked_q,
    input logic                cfg_wr,
    input logic [REG_W-1:0]    cfg_rdata,
    input logic                int_cycle,
    input logic [NUM_PINS-1:0] pin_fsel,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_pu,
    input logic [NUM_PINS-1:0] pin_out
);
    // R1
    mode_held_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[7:6] == 2'b00);

    // R4
    narrow_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OPM_NARROW && locked_q && cfg_wr) |=> $stable(cfg_rdata));

    // R5
    pipe_pair_chk: assert property (@(posedge clk) disable iff (rst)
        pin_fsel[PIN_PIPE0] == pin_fsel[PIN_PIPE1]);

    // R6
    narrow_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OPM_NARROW) |-> !pin_fsel[PIN_STRB]);

    // R8
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ((pin_fsel & ~pin_oe) == '0) && ((pin_fsel & pin_pu) == '0));

    // R9
    narrow_clk_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OPM_NARROW && int_cycle && pin_fsel[PIN_CLK]) |-> !pin_out[PIN_CLK]);
endmodule

bind busctl_pinmux busctl_pinmux_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .locked_q  (locked_q),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .int_cycle (int_cycle),
    .pin_fsel  (pin_fsel),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu),
    .pin_out   (pin_out)
);

// File: tb/test_busctl_pinmux.sv
module test_busctl_pinmux;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       bus_rw = 0, bus_strobe = 0, bus_clk_raw = 0, bus_clk_str = 0;
    logic [1:0] pipe_stat = '0;
    logic       bus_noacc = 0, int_cycle = 0, vis_req = 0;
    logic [5:0] gpio_dout = '0, gpio_ddr = '0;
    logic [5:0] pin_out, pin_oe, pin_pu, pin_fsel;

    int checks = 0;
    int failures = 0;
    bit narrow_m = 0;
    logic [7:0] exp_reg;

    always #(CLK_PERIOD/2) clk = ~clk;

    busctl_pinmux i_busctl_pinmux (.*);

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; mode_sel = m;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        narrow_m = (m == 2'b01);
        exp_reg  = narrow_m ? 8'h08 : 8'h3B;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Pin model taken from R5..R9
    task automatic check_pins(input string req);
        for (int sp = 0; sp < 6; sp++) begin
            for (int gp = 0; gp < 3; gp++) begin
                logic [8:0] s;
                logic [5:0] ef, es, eo, eoe, epu;
                logic csrc;
                s = (sp == 0) ? 9'h000 : (sp == 1) ? 9'h1FF : (sp == 2) ? 9'h0AA :
                    (sp == 3) ? 9'h155 : (sp == 4) ? 9'h1CC : 9'h10C;
                {vis_req, int_cycle, bus_noacc, pipe_stat, bus_clk_str, bus_clk_raw, bus_strobe, bus_rw} = s;
                gpio_dout = (gp == 0) ? 6'h15 : (gp == 1) ? 6'h2A : 6'h3F;
                gpio_ddr  = (gp == 0) ? 6'h0F : (gp == 1) ? 6'h33 : 6'h00;
                #1;
                ef = {exp_reg[5], exp_reg[4], exp_reg[4], !exp_reg[2],
                      exp_reg[1] && !narrow_m, exp_reg[0]};
                csrc = (exp_reg[3] ? bus_clk_str : bus_clk_raw) &&
                       !(int_cycle && !(vis_req && !narrow_m));
                es  = {bus_noacc, pipe_stat[1], pipe_stat[0], csrc, bus_strobe, bus_rw};
                eo  = (ef & es) | (~ef & gpio_dout);
                eoe = ef | gpio_ddr;
                epu = ~ef & ~gpio_ddr;
                checks++;
                if ({pin_fsel, pin_out, pin_oe, pin_pu} !== {ef, eo, eoe, epu}) begin
                    failures++;
                    $display("FAIL %s fsel/out/oe/pu actual=%h/%h/%h/%h expected=%h/%h/%h/%h",
                             req, pin_fsel, pin_out, pin_oe, pin_pu, ef, eo, eoe, epu);
                end
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R1 R2: reset value per mode encoding, including 2'b11 as emulation
        for (int m = 0; m < 4; m++) begin
            do_reset(2'(m));
            chk8("R2 reset value", cfg_rdata, exp_reg);
            check_pins("R5 R7 R8 reset pins");
        end

        // R3: wide and emulation accept every write
        for (int m = 0; m < 3; m += 2) begin
            do_reset(2'(m));
            for (int v = 0; v < 256; v++) begin
                do_write(8'(v));
                exp_reg = 8'(v) & 8'h3F;
                chk8("R3 readback", cfg_rdata, exp_reg);
                if (v % 16 == 5 || v < 64) check_pins("R5 R7 R8 R9 pins");
            end
        end

        // R1: a mode_sel change after reset is ignored (wide mode keeps taking writes)
        do_reset(2'b00);
        @(negedge clk); mode_sel = 2'b01;
        do_write(8'h11);
        do_write(8'h22);
        exp_reg = 8'h22;
        chk8("R1 mode held", cfg_rdata, exp_reg);
        check_pins("R1 pins after mode change");

        // R4 R6: narrow mode, single write after reset
        do_reset(2'b01);
        do_write(8'hFF);
        exp_reg = 8'h3F;
        chk8("R4 first write", cfg_rdata, exp_reg);
        chk8("R6 strobe masked", {7'd0, pin_fsel[1]}, 8'h00);
        check_pins("R6 R9 narrow pins");
        do_write(8'h00);
        chk8("R4 second write ignored", cfg_rdata, 8'h3F);
        do_write(8'h15);
        chk8("R4 third write ignored", cfg_rdata, 8'h3F);
        check_pins("R4 pins unchanged");

        // R4: reset clears the lock; sweep narrow first writes
        for (int v = 0; v < 64; v++) begin
            do_reset(2'b01);
            do_write(8'(v) | 8'hC0);
            exp_reg = 8'(v);
            chk8("R4 first write after reset", cfg_rdata, exp_reg);
            do_write(~8'(v));
            chk8("R4 later write ignored", cfg_rdata, exp_reg);
            check_pins("R6 R7 R8 R9 narrow sweep");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule